// File: doc/BRIEF.md
# Byte-Accessed Timer Counter with Read Coherency

This block is a 16-bit up-counter paced by a power-of-two clock divider. Software reaches it through a narrow register bus with one byte per access. The count, the divider setting and a wrap limit each sit at their own byte address. Because software reads the 16-bit count as two bytes, the first byte read snapshots the whole count into a holding buffer. The second byte then comes from that same instant, even if the counter moved in between.

The counter runs only while the run-select field of the control byte is non-zero and the debug-freeze input is low. Writing any value to either count byte returns the count and the divider to zero. When the counter passes its wrap limit and returns to zero, a one-cycle pulse marks the event. A limit of zero means the full 16-bit range.

While frozen, count reads show the live (held) count rather than any half-finished snapshot. A write to the control byte or to a count byte while frozen discards the snapshot.

Top module: `tmr16_byte`

## Requirements
- R1: After reset the count, the control byte and the wrap limit are zero, `wrap_o` is low, and no snapshot is pending.
- R2: While the run-select field (control bits [4:3]) is zero, neither the count nor the divider's internal progress changes. Counting resumes from the divider position it had reached.
- R3: The divider field (control bits [2:0], value D) makes the count advance once every 2^D enabled clock cycles, for D from 0 to 7.
- R4: When the count equals the wrap limit on an advance, it returns to 0x0000 and `wrap_o` is high for exactly the following cycle. A limit of 0x0000 is treated as 0xFFFF.
- R5: A write of any data to count address 1 or 2 clears the count and the divider in that cycle. It takes priority over an advance or wrap in the same cycle, which then gives no pulse.
- R6: Outside freeze, a count-byte read with no snapshot pending captures the whole count. Reads of count bytes return snapshot bytes while it is pending. Reading the other byte of the pair releases it, so either order (high first or low first) gives a coherent 16-bit value.
- R7: While `freeze_i` is high, the count and the divider hold.
- R8: While `freeze_i` is high, count-byte reads return the live count and leave the snapshot untouched.
- R9: While `freeze_i` is high, a write to the control byte or a count byte discards a pending snapshot. Outside freeze, a control write leaves it in place.
- R10: Address map: 0 control (bits [4:0] read back, upper bits read 0), 1 count high, 2 count low, 3 limit high, 4 limit low. Other addresses read 0x00. Read data is combinational from `bus_addr_i` in the cycle of `bus_rd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Debug freeze: halts counting and changes read and snapshot rules |
| bus_addr_i | input | 3 | Byte register address |
| bus_wr_i | input | 1 | Write strobe, one byte per cycle |
| bus_rd_i | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| wrap_o | output | 1 | One-cycle pulse after the count wraps to zero |

## Verification
Two pairs of events can meet in one clock edge. First, a count-byte write can land on the same edge where the counter would wrap. The bench provokes this at divide-by-1 with a small limit, issuing the write exactly when the count equals the limit. It expects a zero count and no wrap pulse. Second, a snapshot capture can coincide with an increment. This is provoked by reading one byte while the counter advances every cycle, then checking that the other byte shows the pre-increment value rather than the live one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_W = 3;
   localparam int DIV_W  = 3;
   localparam int SEL_W  = 2;
   localparam int CTRL_W = DIV_W + SEL_W;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
   localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
   localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd3;
   localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd4;

   typedef struct packed {
      logic [SEL_W-1:0] run_sel;
      logic [DIV_W-1:0] div_sel;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SEL_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                clr,
   input  logic [SEL_BITS-1:0] div_sel,
   output logic                tick
);
   localparam int PW = (1 << SEL_BITS) - 1;

   initial assert (SEL_BITS >= 1 && SEL_BITS <= 4)
      else $error("tmr_prescaler: SEL_BITS out of range");

   logic [PW-1:0] pq;
   logic [PW:0]   lim;
   logic [PW:0]   lim_m1;
   logic [PW-1:0] mask;

   always_comb begin
      lim    = (PW+1)'(1) << div_sel;
      lim_m1 = lim - (PW+1)'(1);
      mask   = lim_m1[PW-1:0];
   end

   assign tick = en && (pq >= mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pq <= '0;
      else if (clr)    pq <= '0;
      else if (en)     pq <= tick ? '0 : pq + PW'(1);
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         wrap <= 1'b0;
      end else begin
         wrap <= 1'b0;
         if (clr) begin
            cnt <= '0;
         end else if (tick) begin
            if (cnt == top) begin
               cnt  <= '0;
               wrap <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/tmr_rd_latch.sv
module tmr_rd_latch #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze,
   input  logic              rd_hi,
   input  logic              rd_lo,
   input  logic              clr,
   input  logic [CNT_W-1:0]  live,
   output logic [DATA_W-1:0] hi_byte,
   output logic [DATA_W-1:0] lo_byte,
   output logic              valid,
   output logic              first_hi
);
   logic [CNT_W-1:0] snap_q;
   logic             use_snap;

   assign use_snap = valid && !freeze;
   assign hi_byte  = use_snap ? snap_q[CNT_W-1:DATA_W] : live[CNT_W-1:DATA_W];
   assign lo_byte  = use_snap ? snap_q[DATA_W-1:0]     : live[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q   <= '0;
         valid    <= 1'b0;
         first_hi <= 1'b0;
      end else if (clr) begin
         valid <= 1'b0;
      end else if (!freeze && (rd_hi || rd_lo)) begin
         if (!valid) begin
            snap_q   <= live;
            valid    <= 1'b1;
            first_hi <= rd_hi;
         end else if ((rd_hi && !first_hi) || (rd_lo && first_hi)) begin
            valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tmr16_byte.sv
module tmr16_byte
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              wrap_o
);
   localparam int NLANE = CNT_W / DATA_W;

   initial assert (CNT_W == 2 * DATA_W)
      else $error("tmr16_byte: count must be exactly two bytes wide");
   initial assert (DATA_W >= CTRL_W)
      else $error("tmr16_byte: data bus narrower than control byte");

   logic wr_ctrl, cnt_wr, rd_hi, rd_lo;
   assign wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
   assign cnt_wr  = bus_wr_i && ((bus_addr_i == A_CNT_HI) || (bus_addr_i == A_CNT_LO));
   assign rd_hi   = bus_rd_i && (bus_addr_i == A_CNT_HI);
   assign rd_lo   = bus_rd_i && (bus_addr_i == A_CNT_LO);

   tmr_ctrl_t ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
   end

   logic [CNT_W-1:0] lim_flat;
   for (genvar b = 0; b < NLANE; b++) begin : g_lim
      localparam logic [ADDR_W-1:0] LANE_A = A_LIM_LO - ADDR_W'(b);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= '0;
         else if (bus_wr_i && (bus_addr_i == LANE_A))  q <= bus_wdata_i;
      end
      assign lim_flat[b*DATA_W +: DATA_W] = q;
   end

   logic [CNT_W-1:0] top_val;
   assign top_val = (lim_flat == '0) ? '1 : lim_flat;

   logic run, tick;
   assign run = (|ctrl_q.run_sel) && !freeze_i;

   tmr_prescaler #(.SEL_BITS(DIV_W)) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (run),
      .clr     (cnt_wr),
      .div_sel (ctrl_q.div_sel),
      .tick    (tick)
   );

   logic [CNT_W-1:0] cnt_q;
   tmr_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (cnt_wr),
      .top   (top_val),
      .cnt   (cnt_q),
      .wrap  (wrap_o)
   );

   logic [DATA_W-1:0] hi_byte, lo_byte;
   logic lat_valid, lat_first_hi, lat_clr;
   assign lat_clr = cnt_wr || (freeze_i && wr_ctrl);

   tmr_rd_latch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze   (freeze_i),
      .rd_hi    (rd_hi),
      .rd_lo    (rd_lo),
      .clr      (lat_clr),
      .live     (cnt_q),
      .hi_byte  (hi_byte),
      .lo_byte  (lo_byte),
      .valid    (lat_valid),
      .first_hi (lat_first_hi)
   );

   always_comb begin
      case (bus_addr_i)
         A_CTRL:   bus_rdata_o = DATA_W'(ctrl_q);
         A_CNT_HI: bus_rdata_o = hi_byte;
         A_CNT_LO: bus_rdata_o = lo_byte;
         A_LIM_HI: bus_rdata_o = lim_flat[CNT_W-1:DATA_W];
         A_LIM_LO: bus_rdata_o = lim_flat[DATA_W-1:0];
         default:  bus_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              freeze,
   input logic              cnt_wr,
   input logic              ctrl_wr,
   input logic              rd_hi,
   input logic              rd_lo,
   input logic              run_sel,
   input logic [CNT_W-1:0]  cnt,
   input logic              wrap,
   input logic [DATA_W-1:0] rdata,
   input logic              lat_valid,
   input logic              lat_first_hi
);
   p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_sel && !cnt_wr) |=> $stable(cnt));

   p_wrap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> !wrap);

   p_wrap_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> (cnt == '0));

   p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> ((cnt == '0) && !wrap));

   p_release_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_valid && !freeze && !cnt_wr &&
       ((rd_lo && lat_first_hi) || (rd_hi && !lat_first_hi))) |=> !lat_valid);

   p_freeze_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !cnt_wr) |=> $stable(cnt));

   p_freeze_read_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && rd_lo) |-> (rdata == cnt[DATA_W-1:0]));

   p_freeze_write_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && (ctrl_wr || cnt_wr)) |=> !lat_valid);
endmodule

bind tmr16_byte tmr16_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .freeze       (freeze_i),
   .cnt_wr       (cnt_wr),
   .ctrl_wr      (wr_ctrl),
   .rd_hi        (rd_hi),
   .rd_lo        (rd_lo),
   .run_sel      (|ctrl_q.run_sel),
   .cnt          (cnt_q),
   .wrap         (wrap_o),
   .rdata        (bus_rdata_o),
   .lat_valid    (lat_valid),
   .lat_first_hi (lat_first_hi)
);

// File: tb/test_tmr16_byte.sv
`timescale 1ns/1ps
module test_tmr16_byte;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       freeze_i = 1'b0;
   logic [2:0] bus_addr_i = '0;
   logic       bus_wr_i = 1'b0;
   logic       bus_rd_i = 1'b0;
   logic [7:0] bus_wdata_i = '0;
   logic [7:0] bus_rdata_o;
   logic       wrap_o;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [2:0] AC = 3'd0, AH = 3'd1, AL = 3'd2, MH = 3'd3, ML = 3'd4;

   always #2.5 clk = ~clk;

   tmr16_byte i_tmr16_byte (
      .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i),
      .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .wrap_o(wrap_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
      @(negedge clk);
      bus_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr_i = a; bus_rd_i = 1'b1;
      #1 d = bus_rdata_o;
      @(negedge clk);
      bus_rd_i = 1'b0;
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] h, l;
      rd(AH, h);
      rd(AL, l);
      v = {h, l};
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_lim(input logic [15:0] v);
      wr(MH, v[15:8]);
      wr(ML, v[7:0]);
   endtask

   task automatic t_reset;
      logic [15:0] v; logic [7:0] c;
      chk("R1 wrap after reset", wrap_o, 0);
      rd16(v);
      chk("R1 count after reset", v, 16'h0000);
      rd(AC, c);
      chk("R1 control after reset", c, 8'h00);
      rd(ML, c);
      chk("R1 limit after reset", c, 8'h00);
   endtask

   task automatic t_regmap;
      logic [7:0] c;
      wr(AC, 8'hFF);
      rd(AC, c);
      chk("R10 control readback 5 bits", c, 8'h1F);
      set_lim(16'h1234);
      rd(MH, c);
      chk("R10 limit high readback", c, 8'h12);
      rd(ML, c);
      chk("R10 limit low readback", c, 8'h34);
      rd(3'd5, c);
      chk("R10 unused address reads zero", c, 8'h00);
      wr(AC, 8'h00);
      set_lim(16'h0000);
   endtask

   task automatic t_hold;
      logic [15:0] v;
      wr(AC, 8'h0A);
      wr(AL, 8'h5A);
      wait_n(2);
      wr(AC, 8'h02);
      wait_n(10);
      rd16(v);
      chk("R2 count holds with run-select zero", v, 16'h0000);
      wr(AC, 8'h0A);
      wait_n(1);
      rd16(v);
      chk("R2 divider progress kept while stopped", v, 16'h0001);
   endtask

   task automatic t_prescale;
      logic [15:0] v;
      wr(AC, 8'h08);
      wr(AL, 8'h00);
      wait_n(37);
      rd16(v);
      chk("R3 divide by 1", v, 16'd37);
      wr(AC, 8'h0B);
      wr(AL, 8'h00);
      wait_n(40);
      rd16(v);
      chk("R3 divide by 8", v, 16'd5);
      wr(AC, 8'h0F);
      wr(AL, 8'h00);
      wait_n(300);
      rd16(v);
      chk("R3 divide by 128", v, 16'd2);
   endtask

   task automatic t_modulo;
      int pulses = 0;
      logic [15:0] v;
      wr(AC, 8'h08);
      set_lim(16'd5);
      wr(AL, 8'h00);
      for (int i = 1; i <= 60; i++) begin
         wait_n(1);
         if (wrap_o) pulses++;
         if (i == 5) chk("R4 no pulse before limit", wrap_o, 0);
         if (i == 6) chk("R4 pulse after wrap from limit", wrap_o, 1);
         if (i == 7) chk("R4 pulse lasts one cycle", wrap_o, 0);
      end
      chk("R4 pulse count over 60 cycles", pulses, 10);
      rd16(v);
      chk("R4 count after whole periods", v, 16'h0000);
   endtask

   task automatic t_full;
      logic [7:0] h, l;
      wr(AC, 8'h08);
      set_lim(16'h0000);
      wr(AL, 8'h00);
      wait_n(65535);
      chk("R4 no pulse at 0xFFFF", wrap_o, 0);
      rd(AL, l);
      chk("R4 pulse after full-range wrap", wrap_o, 1);
      rd(AH, h);
      chk("R4 pulse ends", wrap_o, 0);
      chk("R6 snapshot 0xFFFF across wrap", {h, l}, 16'hFFFF);
   endtask

   task automatic t_clear;
      logic [15:0] v;
      wr(AC, 8'h0B);
      wr(AL, 8'h00);
      wait_n(20);
      wr(AH, 8'hA5);
      wait_n(7);
      rd16(v);
      chk("R5 high-byte write clears count and divider", v, 16'h0000);
   endtask

   task automatic t_collide;
      logic [15:0] v;
      wr(AC, 8'h08);
      set_lim(16'd3);
      wr(AL, 8'h00);
      wait_n(3);
      wr(AL, 8'hC3);
      chk("R5 write beats wrap: no pulse", wrap_o, 0);
      rd16(v);
      chk("R5 write beats wrap: count zero", v, 16'h0000);
      set_lim(16'h0000);
   endtask

   task automatic t_coherent;
      logic [7:0] h, l;
      wr(AC, 8'h08);
      wr(AL, 8'h00);
      wait_n(255);
      rd(AH, h);
      chk("R6 high first: live high", h, 8'h00);
      rd(AL, l);
      chk("R6 high first: snapshot low", l, 8'hFF);
      rd(AL, l);
      chk("R6 released: fresh low", l, 8'h01);
      rd(AH, h);
      chk("R6 low first: snapshot high", h, 8'h01);
      wr(AL, 8'h00);
      wait_n(255);
      rd(AL, l);
      chk("R6 low first: live low", l, 8'hFF);
      rd(AH, h);
      chk("R6 low first: pre-increment high", h, 8'h00);
   endtask

   task automatic t_freeze;
      logic [7:0] h, l;
      wr(AC, 8'h08);
      wr(AL, 8'h00);
      wait_n(3);
      rd(AH, h);
      freeze_i = 1'b1;
      wait_n(5);
      rd(AL, l);
      chk("R8 frozen read is live, not snapshot", l, 8'h04);
      wait_n(10);
      rd(AL, l);
      chk("R7 count held under freeze", l, 8'h04);
      wr(AC, 8'h08);
      freeze_i = 1'b0;
      rd(AL, l);
      chk("R9 control write in freeze dropped snapshot", l, 8'h04);
      rd(AH, h);
      wr(AL, 8'h00);
      wait_n(3);
      rd(AH, h);
      wr(AC, 8'h08);
      rd(AL, l);
      chk("R9 control write outside freeze keeps snapshot", l, 8'h03);
      wr(AL, 8'h00);
      wait_n(6);
      rd(AH, h);
      freeze_i = 1'b1;
      wr(AH, 8'h33);
      freeze_i = 1'b0;
      wait_n(2);
      rd(AL, l);
      chk("R9 count write in freeze dropped snapshot", l, 8'h02);
      rd(AH, h);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_hold();
      t_prescale();
      t_modulo();
      t_clear();
      t_collide();
      t_coherent();
      t_freeze();
      t_full();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule